// File: doc/BRIEF.md
# BCD Repeated-Addition Multiply/Divide Sequencer

This block runs two arithmetic sequences on 12-digit packed BCD mantissas. Both work by adding an operand X into an accumulator Y once per clock cycle through a combinational decimal adder. Digits are packed four bits each, with the most significant digit in bits 47:44.

In multiply mode, X is added to Y as many times as the low four bits of the B word say. The number of decimal overflows seen along the way is returned in the low nibble of the A word. In divide mode, X is added until the first addition that carries out of the top digit. The number of additions that did not overflow is returned in the low nibble of B.

A caller presents the operands and the opcode with a one-cycle `start` strobe. It then waits for the one-cycle `done` pulse and reads Y, A, B and the decimal-carry flag from the output registers.

Top module: `bcd_repeat_seq`

## Requirements
- R1: With `op`=0 (multiply) and N = `b_in[3:0]`, the final `y_out` equals (`y_in` + N·`x_in`) mod 10^12 in packed BCD, with the most significant digit in bits 47:44.
- R2: After a multiply, `a_out[3:0]` holds the number of intermediate decimal overflows modulo 16, and `a_out[15:4]` is zero.
- R3: A multiply with N=0 leaves `y_out` equal to `y_in` and returns 0 in `a_out`, with `done` one cycle after the start edge.
- R4: With `op`=1 (divide), X is added into Y until an addition carries out of the top digit. That overflowing sum, wrapped to 12 digits, is still written to `y_out`. `b_out[3:0]` holds the count of additions that did not overflow, and `b_out[15:4]` is zero.
- R5: Divide stops after 15 additions without overflow and returns 15. If the 15th addition overflows, it returns 14.
- R6: `dc_out` is 0 when `done` is high and stays 0 while idle after any sequence.
- R7: `done` is a one-cycle pulse that never coincides with `busy`. It rises max(N,1) cycles after the start edge for multiply, and k cycles after it for a divide that made k additions.
- R8: A `start` seen while busy is ignored. Multiply leaves `b_out` equal to the `b_in` it started with, and divide leaves `a_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence when idle |
| op | input | 1 | 0 = multiply, 1 = divide |
| x_in | input | 48 | Addend mantissa X, packed BCD |
| y_in | input | 48 | Initial accumulator mantissa Y, packed BCD |
| b_in | input | 16 | B word; bits 3:0 give the multiply count |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| y_out | output | 48 | Accumulator result |
| a_out | output | 16 | A word; multiply overflow count in bits 3:0 |
| b_out | output | 16 | B word; divide count in bits 3:0 |
| dc_out | output | 1 | Decimal carry flag |

## Verification
The delicate coincidence is a decimal overflow that lands on the final step of a sequence. In multiply, the last addition overflows and its carry must still enter the count. In divide, the fifteenth addition overflows, so the overflow must take precedence over the count limit. The bench provokes the first case by sweeping every count from 0 to 15 with operands that overflow on most additions. It provokes the second with X = 66666666667 from zero, and an operand pair that overflows on its very first addition gives the related count-zero corner. Each result is judged against counts and sums computed in plain integer arithmetic.

// File: rtl/bcd_seq_pkg.sv
package bcd_seq_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } seq_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] digit;
        logic               carry;
    } digit_sum_t;

    // One decimal digit position: binary add, then correct by six above nine.
    function automatic digit_sum_t digit_add(input logic [DIGIT_W-1:0] a,
                                             input logic [DIGIT_W-1:0] b,
                                             input logic               ci);
        digit_sum_t       r;
        logic [DIGIT_W:0] raw;
        raw = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, ci};
        if (raw > 5'd9) begin
            r.digit = raw[DIGIT_W-1:0] + 4'd6;
            r.carry = 1'b1;
        end else begin
            r.digit = raw[DIGIT_W-1:0];
            r.carry = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
    import bcd_seq_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               ci,
    output logic [DIGIT_W-1:0] s,
    output logic               co
);
    digit_sum_t res;

    always_comb begin
        res = digit_add(a, b, ci);
        s   = res.digit;
        co  = res.carry;
    end
endmodule

// File: rtl/bcd_word_add.sv
module bcd_word_add
    import bcd_seq_pkg::*;
#(
    parameter int DIGITS = 12,
    localparam int MANT_W = DIGITS * DIGIT_W
) (
    input  logic [MANT_W-1:0] a,
    input  logic [MANT_W-1:0] b,
    output logic [MANT_W-1:0] sum,
    output logic              carry
);
    logic [DIGITS:0] chain;

    assign chain[0] = 1'b0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_add u_dig (
            .a  (a[g*DIGIT_W +: DIGIT_W]),
            .b  (b[g*DIGIT_W +: DIGIT_W]),
            .ci (chain[g]),
            .s  (sum[g*DIGIT_W +: DIGIT_W]),
            .co (chain[g+1])
        );
    end

    assign carry = chain[DIGITS];
endmodule

// File: rtl/bcd_repeat_seq.sv
module bcd_repeat_seq
    import bcd_seq_pkg::*;
#(
    parameter int DIGITS = 12,
    parameter int CNT_W  = 4,
    parameter int WORD_W = 16,
    localparam int MANT_W  = DIGITS * DIGIT_W,
    localparam int CNT_MAX = (1 << CNT_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op,
    input  logic [MANT_W-1:0] x_in,
    input  logic [MANT_W-1:0] y_in,
    input  logic [WORD_W-1:0] b_in,
    output logic              busy,
    output logic              done,
    output logic [MANT_W-1:0] y_out,
    output logic [WORD_W-1:0] a_out,
    output logic [WORD_W-1:0] b_out,
    output logic              dc_out
);
    seq_state_e        state_q;
    seq_op_e           op_q;
    logic [MANT_W-1:0] x_q, y_q;
    logic [CNT_W-1:0]  rem_q, cnt_q, ovf_q;
    logic [WORD_W-1:0] a_q, b_q;
    logic              dc_q, done_q;

    logic [MANT_W-1:0] add_sum;
    logic              add_carry;
    logic [CNT_W-1:0]  ovf_next;

    bcd_word_add #(.DIGITS(DIGITS)) u_add (
        .a     (y_q),
        .b     (x_q),
        .sum   (add_sum),
        .carry (add_carry)
    );

    assign ovf_next = ovf_q + {{(CNT_W-1){1'b0}}, add_carry};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_MUL;
            x_q     <= '0;
            y_q     <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            ovf_q   <= '0;
            a_q     <= '0;
            b_q     <= '0;
            dc_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        op_q    <= seq_op_e'(op);
                        x_q     <= x_in;
                        y_q     <= y_in;
                        b_q     <= b_in;
                        rem_q   <= b_in[CNT_W-1:0];
                        cnt_q   <= '0;
                        ovf_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (op_q == OP_MUL) begin
                        if (rem_q == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            dc_q    <= 1'b0;
                            a_q     <= {{(WORD_W-CNT_W){1'b0}}, ovf_q};
                        end else begin
                            y_q   <= add_sum;
                            rem_q <= rem_q - 1'b1;
                            if (rem_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                                dc_q    <= 1'b0;
                                a_q     <= {{(WORD_W-CNT_W){1'b0}}, ovf_next};
                            end else begin
                                ovf_q <= ovf_next;
                                dc_q  <= add_carry;
                            end
                        end
                    end else begin
                        y_q <= add_sum;
                        if (add_carry) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            dc_q    <= 1'b0;
                            b_q     <= {{(WORD_W-CNT_W){1'b0}}, cnt_q};
                        end else if (cnt_q == CNT_W'(CNT_MAX - 1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            dc_q    <= 1'b0;
                            b_q     <= {{(WORD_W-CNT_W){1'b0}}, CNT_W'(CNT_MAX)};
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            dc_q  <= 1'b0;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q == ST_RUN);
    assign done   = done_q;
    assign y_out  = y_q;
    assign a_out  = a_q;
    assign b_out  = b_q;
    assign dc_out = dc_q;

    // R7: done lasts exactly one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: done never overlaps busy
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6: decimal carry is clear at completion
    a_r6_dc_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> !dc_out);

    // R8: B stays put while a sequence keeps running
    a_r8_b_stable: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(b_out));

    // R8: A is untouched by a divide
    a_r8_div_keeps_a: assert property (@(posedge clk) disable iff (rst)
        done && op_q == OP_DIV |-> $stable(a_out));

    // R4: divide result upper B bits are zero
    a_r4_b_upper: assert property (@(posedge clk) disable iff (rst)
        done && op_q == OP_DIV |-> b_out[WORD_W-1:CNT_W] == '0);

    // R5: the divide success counter never reaches the limit while running
    a_r5_div_cap: assert property (@(posedge clk) disable iff (rst)
        busy && op_q == OP_DIV |-> cnt_q < CNT_W'(CNT_MAX));

    // R2: multiply leaves A upper bits zero
    a_r2_a_upper: assert property (@(posedge clk) disable iff (rst)
        done && op_q == OP_MUL |-> a_out[WORD_W-1:CNT_W] == '0);
endmodule

// File: tb/bcd_repeat_seq_test.sv
module bcd_repeat_seq_test;
    localparam longint MOD = 64'd1000000000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op = 1'b0;
    logic [47:0] x_in = '0, y_in = '0;
    logic [15:0] b_in = '0;
    logic        busy, done, dc_out;
    logic [47:0] y_out;
    logic [15:0] a_out, b_out;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bcd_repeat_seq uut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .x_in(x_in), .y_in(y_in), .b_in(b_in),
        .busy(busy), .done(done), .y_out(y_out),
        .a_out(a_out), .b_out(b_out), .dc_out(dc_out)
    );

    function automatic logic [47:0] to_bcd(input longint v);
        logic [47:0] r;
        longint t;
        t = v;
        for (int i = 0; i < 12; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input logic o, input longint x, input longint y,
                       input logic [15:0] b, input bit inject, output int lat);
        @(negedge clk);
        op = o; x_in = to_bcd(x); y_in = to_bcd(y); b_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        chk("R7 busy after start", longint'(busy), 1);
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
            if (inject && lat == 2) begin
                start = 1'b1; op = 1'b1; y_in = '0; b_in = 16'h0003;
            end else begin
                start = 1'b0;
            end
            if (done) chk("R7 busy low at done", longint'(busy), 0);
        end
        start = 1'b0;
    endtask

    task automatic do_mul(input longint x, input longint y, input int n, input bit inject);
        longint acc;
        int ovf, lat, explat;
        logic [15:0] bw;
        acc = y; ovf = 0;
        for (int i = 0; i < n; i++) begin
            acc = acc + x;
            if (acc >= MOD) begin acc = acc - MOD; ovf++; end
        end
        explat = (n == 0) ? 1 : n;
        bw = 16'hA5A0 | 16'(n);
        run(1'b0, x, y, bw, inject, lat);
        chk(n == 0 ? "R3 mul zero y" : "R1 mul y", longint'(y_out), longint'(to_bcd(acc)));
        chk(n == 0 ? "R3 mul zero a" : "R2 mul a", longint'(a_out), longint'(ovf % 16));
        chk("R7 mul latency", longint'(lat), longint'(explat));
        chk("R8 mul keeps b", longint'(b_out), longint'(bw));
        chk("R6 dc clear", longint'(dc_out), 0);
        @(negedge clk);
        chk("R7 done one cycle", longint'(done), 0);
        chk("R6 dc idle", longint'(dc_out), 0);
    endtask

    task automatic do_div(input longint x, input longint y);
        longint acc, s;
        int k, adds, lat;
        logic [15:0] a_before;
        acc = y; k = 0; adds = 0;
        while (1) begin
            s = acc + x; adds++;
            if (s >= MOD) begin acc = s - MOD; break; end
            acc = s; k++;
            if (k == 15) break;
        end
        a_before = a_out;
        run(1'b1, x, y, 16'hFFF7, 1'b0, lat);
        chk(k == 15 || adds == 15 ? "R5 div y" : "R4 div y", longint'(y_out), longint'(to_bcd(acc)));
        chk(k == 15 || adds == 15 ? "R5 div b" : "R4 div b", longint'(b_out), longint'(k));
        chk("R7 div latency", longint'(lat), longint'(adds));
        chk("R8 div keeps a", longint'(a_out), longint'(a_before));
        chk("R6 dc clear", longint'(dc_out), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset busy", longint'(busy), 0);
        chk("R7 reset done", longint'(done), 0);
        chk("R1 reset y", longint'(y_out), 0);
        chk("R2 reset a", longint'(a_out), 0);
        chk("R4 reset b", longint'(b_out), 0);
        chk("R6 reset dc", longint'(dc_out), 0);

        for (int n = 0; n < 16; n++) begin
            do_mul(64'd123456789012, 64'd0, n, 1'b0);
            do_mul(64'd999999999999, 64'd1, n, 1'b0);
            do_mul(64'd500000000000, 64'd500000000000, n, 1'b0);
            do_mul(64'd1, 64'd999999999998, n, 1'b0);
        end
        // R8: start pulse during a running multiply must be ignored
        do_mul(64'd700000000003, 64'd123, 5, 1'b1);

        do_div(64'd300000000000, 64'd200000000000);
        do_div(64'd1, 64'd0);
        do_div(64'd500000000000, 64'd0);
        do_div(64'd0, 64'd424242424242);
        do_div(64'd66666666667, 64'd0);
        do_div(64'd999999999999, 64'd999999999999);
        do_div(64'd99999999999, 64'd50000000000);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule